// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address from a processor into a physical address. It does this by reading a two-level translation table that lives in ordinary memory. The upper ten bits of the virtual address pick an entry in a first-level directory, and the directory is located by a base address supplied alongside the request. That directory entry names the page holding a second-level table. The next ten bits pick the final (leaf) entry in that table. The low twelve bits are the offset within a 4 KB page and are carried straight through to the result.

Each request carries an access kind: read, write or execute. The walker checks the valid bit of both entries it reads, and checks the leaf entry's permission bits against the access kind. It then finishes with either a physical address or a fault code. When a permitted write lands on a page whose dirty bit is still clear, the walker writes the leaf entry back to memory with the dirty bit set before it reports completion.

The walker handles one translation at a time. Table entries are fetched through a simple request/response port: reads return one response each, and writes complete when they are accepted.

Top module: `xlate_walker`

## Requirements
- R1: `req_ready` is high only while no walk is in progress. A request is taken on a cycle where both `req_valid` and `req_ready` are high, and `req_ready` stays low from then until the cycle after `done`. No memory request is issued while `req_ready` is high.
- R2: The first memory read goes to `{tbl_base[31:12], 12'h000} + 4 * vaddr[31:22]`. The low twelve bits of `tbl_base` have no effect, and `tbl_base` is sampled when the request is taken.
- R3: The second memory read goes to `{dir[31:12], 12'h000} + 4 * vaddr[21:12]`, where `dir` is the directory entry just returned.
- R4: If bit 0 (valid) of the directory entry or of the leaf entry is 0, the walk ends with fault code 1 and `paddr` equal to 0. A clear directory valid bit ends the walk without a second read.
- R5: The leaf permission bits are bit 1 = readable, bit 2 = writable and bit 3 = executable. Access kind 0 is read, 1 is write and 2 is execute; kind 3 is never permitted. A denied access ends with fault code 2, `paddr` equal to 0, and no memory write.
- R6: A permitted access ends with fault code 0 and `paddr = {leaf[31:12], vaddr[11:0]}`.
- R7: A permitted write whose leaf bit 4 (dirty) is 0 issues exactly one memory write to the leaf entry's address. The data written is the leaf entry with bit 4 set, and the write happens before `done`. Writes with the dirty bit already set, and all reads and executes, issue no memory write.
- R8: `done` is high for exactly one cycle per translation. A memory request that is not yet accepted keeps its address and direction until `mem_req_ready` is high.
- R9: Fault codes are 0 = none, 1 = invalid entry, 2 = protection. Code 3 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| tbl_base | input | 32 | Directory base address; bits 31:12 used |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_req_wdata | output | 32 | Entry value for a write-back |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Returned table entry |
| done | output | 1 | One-cycle completion strobe |
| fault | output | 2 | Fault code, valid with `done` |
| paddr | output | 32 | Physical address, valid with `done` |

## Verification
The hardest case to reach from the ports is the dirty write-back. It requires a write whose two entries are both valid, whose leaf grants write permission and whose dirty bit is clear, and the write-back must then get through while the memory is refusing some requests. The bench uses a memory model that drops `mem_req_ready` on a fixed cycle pattern, so every request, including the write-back, has to hold against back-pressure. It then sends the same write a second time: the entry the block itself rewrote must now produce no second write. The fault paths are reached by building entries with one bit removed at a time, and the address arithmetic is pushed to both index extremes and to a base address with junk in its low bits.

// File: rtl/xlate_pkg.sv
`timescale 1ns/1ps
package xlate_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_INVALID = 2'd1,
    FLT_PROT    = 2'd2
  } flt_e;

  typedef enum logic [2:0] {
    S_IDLE, S_DIR_RQ, S_DIR_WT, S_LEAF_RQ, S_LEAF_WT, S_WB_RQ, S_DONE
  } st_e;

  // entry flag positions (low bits of every table entry)
  localparam int unsigned ENT_V  = 0;
  localparam int unsigned ENT_R  = 1;
  localparam int unsigned ENT_W  = 2;
  localparam int unsigned ENT_X  = 3;
  localparam int unsigned ENT_D  = 4;
  localparam int unsigned FLAG_W = 5;
endpackage

// File: rtl/xlate_ent_addr.sv
`timescale 1ns/1ps
module xlate_ent_addr #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned IDX_W  = 10
) (
  input  logic [ADDR_W-OFF_W-1:0] base_pn,
  input  logic [IDX_W-1:0]        idx,
  output logic [ADDR_W-1:0]       ent_addr
);
  localparam int unsigned PAD_W = ADDR_W - IDX_W - 2;

  // word-sized entries: table page base plus index scaled by four
  assign ent_addr = {base_pn, {OFF_W{1'b0}}} + {{PAD_W{1'b0}}, idx, 2'b00};
endmodule

// File: rtl/xlate_perm_chk.sv
`timescale 1ns/1ps
module xlate_perm_chk
  import xlate_pkg::*;
#(
  parameter bit DIRTY_WB = 1'b1
) (
  input  logic [FLAG_W-1:0] flags,
  input  acc_e              kind,
  output logic              allow,
  output logic              need_wb
);
  always_comb begin
    unique case (kind)
      ACC_READ:  allow = flags[ENT_R];
      ACC_WRITE: allow = flags[ENT_W];
      ACC_EXEC:  allow = flags[ENT_X];
      default:   allow = 1'b0;
    endcase
  end

  generate
    if (DIRTY_WB) begin : g_dirty
      assign need_wb = flags[ENT_V] && allow && (kind == ACC_WRITE) && !flags[ENT_D];
    end else begin : g_no_dirty
      assign need_wb = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/xlate_ctrl.sv
`timescale 1ns/1ps
module xlate_ctrl
  import xlate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic mem_req_ready,
  input  logic mem_rsp_valid,
  input  logic ent_v,
  input  logic allow,
  input  logic need_wb,
  output st_e  state
);
  st_e state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      S_IDLE:    if (req_valid)     state_nx = S_DIR_RQ;
      S_DIR_RQ:  if (mem_req_ready) state_nx = S_DIR_WT;
      S_DIR_WT:  if (mem_rsp_valid) state_nx = ent_v ? S_LEAF_RQ : S_DONE;
      S_LEAF_RQ: if (mem_req_ready) state_nx = S_LEAF_WT;
      S_LEAF_WT: if (mem_rsp_valid) begin
                   if (!ent_v || !allow) state_nx = S_DONE;
                   else if (need_wb)     state_nx = S_WB_RQ;
                   else                  state_nx = S_DONE;
                 end
      S_WB_RQ:   if (mem_req_ready) state_nx = S_DONE;
      S_DONE:    state_nx = S_IDLE;
      default:   state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= state_nx;
  end
endmodule

// File: rtl/xlate_walker.sv
`timescale 1ns/1ps
module xlate_walker
  import xlate_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned OFF_W    = 12,
  parameter int unsigned IDX_W    = 10,
  parameter bit          DIRTY_WB = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] tbl_base,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [ADDR_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              done,
  output logic [1:0]        fault,
  output logic [ADDR_W-1:0] paddr
);
  localparam int unsigned PN_W = ADDR_W - OFF_W;

  st_e               state;
  logic [ADDR_W-1:0] vaddr_q;
  acc_e              kind_q;
  logic [PN_W-1:0]   base_pn_q;
  logic [PN_W-1:0]   dir_pn_q;
  logic [ADDR_W-1:0] leaf_q;
  logic [1:0]        fault_q;
  logic [ADDR_W-1:0] paddr_q;
  logic [ADDR_W-1:0] dir_addr, leaf_addr;
  logic              allow, need_wb, ent_v;
  logic              fire, dir_rsp, leaf_rsp;
  logic              res_en;
  logic [1:0]        res_flt;
  logic [ADDR_W-1:0] res_pa;
  logic              unused_base_low;

  assign unused_base_low = ^tbl_base[OFF_W-1:0];

  assign fire     = req_valid && req_ready;
  assign dir_rsp  = (state == S_DIR_WT)  && mem_rsp_valid;
  assign leaf_rsp = (state == S_LEAF_WT) && mem_rsp_valid;
  assign ent_v    = mem_rsp_data[ENT_V];

  xlate_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .ent_v         (ent_v),
    .allow         (allow),
    .need_wb       (need_wb),
    .state         (state)
  );

  xlate_perm_chk #(.DIRTY_WB(DIRTY_WB)) u_perm (
    .flags   (mem_rsp_data[FLAG_W-1:0]),
    .kind    (kind_q),
    .allow   (allow),
    .need_wb (need_wb)
  );

  xlate_ent_addr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_dir_addr (
    .base_pn  (base_pn_q),
    .idx      (vaddr_q[ADDR_W-1 -: IDX_W]),
    .ent_addr (dir_addr)
  );

  xlate_ent_addr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_leaf_addr (
    .base_pn  (dir_pn_q),
    .idx      (vaddr_q[OFF_W +: IDX_W]),
    .ent_addr (leaf_addr)
  );

  // result of the walk, captured as the controller heads for S_DONE
  always_comb begin
    res_en  = 1'b0;
    res_flt = FLT_NONE;
    res_pa  = '0;
    if (dir_rsp && !ent_v) begin
      res_en  = 1'b1;
      res_flt = FLT_INVALID;
    end else if (leaf_rsp) begin
      res_en = 1'b1;
      if (!ent_v)      res_flt = FLT_INVALID;
      else if (!allow) res_flt = FLT_PROT;
      else             res_pa  = {mem_rsp_data[ADDR_W-1:OFF_W], vaddr_q[OFF_W-1:0]};
    end
  end

  // request context, loaded only when a request is taken
  always_ff @(posedge clk) begin
    if (fire) begin
      vaddr_q   <= req_vaddr;
      kind_q    <= acc_e'(req_kind);
      base_pn_q <= tbl_base[ADDR_W-1:OFF_W];
    end
  end

  always_ff @(posedge clk) begin
    if (dir_rsp)  dir_pn_q <= mem_rsp_data[ADDR_W-1:OFF_W];
    if (leaf_rsp) leaf_q   <= mem_rsp_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= FLT_NONE;
      paddr_q <= '0;
    end else if (res_en) begin
      fault_q <= res_flt;
      paddr_q <= res_pa;
    end
  end

  assign req_ready     = (state == S_IDLE);
  assign mem_req_valid = (state == S_DIR_RQ) || (state == S_LEAF_RQ) || (state == S_WB_RQ);
  assign mem_req_write = (state == S_WB_RQ);
  assign mem_req_addr  = (state == S_DIR_RQ) ? dir_addr : leaf_addr;
  assign mem_req_wdata = leaf_q | (ADDR_W'(1) << ENT_D);
  assign done          = (state == S_DONE);
  assign fault         = fault_q;
  assign paddr         = paddr_q;
endmodule

// File: rtl/xlate_walker_chk.sv
`timescale 1ns/1ps
module xlate_walker_chk
  import xlate_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic        mem_req_write,
  input logic [31:0] mem_req_addr,
  input logic [31:0] mem_req_wdata,
  input logic        done,
  input logic [1:0]  fault,
  input logic [31:0] paddr
);
  assert_one_walk_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  assert_no_mem_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  // covers R5 as well: every faulting completion carries a zero address
  assert_fault_zero_pa_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done && (fault != 2'd0) |-> paddr == '0);

  assert_wb_sets_dirty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write |-> mem_req_wdata[ENT_D] && mem_req_wdata[ENT_V]);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));

  assert_fault_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> fault != 2'd3);
endmodule

bind xlate_walker xlate_walker_chk u_chk (.*);

// File: tb/xlate_walker_tb.sv
`timescale 1ns/1ps
module xlate_walker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 20000;

  typedef struct {
    logic [1:0]  flt;
    logic [31:0] pa;
    int          wb;
    logic [31:0] wb_addr;
    int          wr_base;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_vaddr;
  logic [1:0]  req_kind;
  logic [31:0] tbl_base;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic        mem_req_write;
  logic [31:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        done;
  logic [1:0]  fault;
  logic [31:0] paddr;

  int n_checks = 0;
  int n_fails  = 0;
  int n_sent   = 0;
  int n_seen   = 0;
  int wr_count = 0;
  int cyc      = 0;
  exp_t exp_q[$];
  logic [31:0] mem [logic [31:0]];

  always #(CLK_PERIOD/2) clk = ~clk;

  xlate_walker u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_kind(req_kind), .tbl_base(tbl_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .fault(fault), .paddr(paddr)
  );

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // memory model: refuses every third cycle, answers reads one cycle later
  assign mem_req_ready = (cyc % 3) != 1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
      cyc = 0;
    end else begin
      cyc = cyc + 1;
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_write) begin
          mem[mem_req_addr] = mem_req_wdata;
          wr_count = wr_count + 1;
        end else begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= rd(mem_req_addr);
        end
      end
    end
  end

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // monitor: pops expectations as completions appear
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        check("R8", "unexpected completion", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, "fault code", {30'd0, fault}, {30'd0, e.flt});
        check(e.tag, "physical address", paddr, e.pa);
        check("R7", "write-back count", 32'(wr_count - e.wr_base), 32'(e.wb));
        if (e.wb != 0)
          check("R7", "dirty bit in memory", {31'd0, rd(e.wb_addr)[4]}, 32'd1);
      end
      n_seen++;
    end
  end

  // table layout used by the bench: directory slot d points at page 0x200+d
  function automatic logic [31:0] leaf_loc(input int d, input int t);
    return ((32'h200 + 32'(d)) << 12) + 32'(t) * 4;
  endfunction

  task automatic set_dir(input logic [31:0] base, input int d, input bit v);
    mem[{base[31:12], 12'h0} + 32'(d) * 4] = ((32'h200 + 32'(d)) << 12) | {31'd0, v};
  endtask

  // reference walk from the requirements
  task automatic send(input logic [31:0] va, input logic [1:0] kind,
                      input logic [31:0] base, input string tag);
    exp_t e;
    logic [31:0] de, le;
    bit ok;
    e.tag = tag; e.wb = 0; e.wb_addr = '0; e.pa = '0; e.flt = 2'd0;
    de = rd({base[31:12], 12'h0} + {20'd0, va[31:22], 2'b00});
    if (!de[0]) e.flt = 2'd1;
    else begin
      e.wb_addr = {de[31:12], 12'h0} + {20'd0, va[21:12], 2'b00};
      le = rd(e.wb_addr);
      ok = (kind == 2'd0) ? le[1] : (kind == 2'd1) ? le[2] : (kind == 2'd2) ? le[3] : 1'b0;
      if (!le[0])  e.flt = 2'd1;
      else if (!ok) e.flt = 2'd2;
      else begin
        e.pa = {le[31:12], va[11:0]};
        e.wb = (kind == 2'd1 && !le[4]) ? 1 : 0;
      end
    end
    while (!req_ready) @(negedge clk);
    e.wr_base = wr_count;
    exp_q.push_back(e);
    n_sent++;
    req_valid = 1'b1; req_vaddr = va; req_kind = kind; tbl_base = base;
    @(negedge clk);
    req_valid = 1'b0;
    tbl_base  = 32'hDEAD_B000; // later changes must not matter (R2)
    check("R1", "ready low during walk", {31'd0, req_ready}, 32'd0);
    while (n_seen < n_sent) @(negedge clk);
    @(negedge clk);
    check("R8", "done drops after one cycle", {31'd0, done}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < WDOG_LIMIT; i++) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [31:0] b;
    b = 32'h0001_0000;
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_kind = '0; tbl_base = '0;
    repeat (3) @(negedge clk);
    check("R1", "reset ready", {31'd0, req_ready}, 32'd1);
    check("R8", "reset done", {31'd0, done}, 32'd0);
    check("R1", "reset mem request", {31'd0, mem_req_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    set_dir(b, 1, 1'b1);
    set_dir(b, 2, 1'b0);
    set_dir(b, 0, 1'b1);
    set_dir(b, 1023, 1'b1);
    mem[leaf_loc(1, 1)]    = 32'h12345_003;  // V R
    mem[leaf_loc(1, 2)]    = 32'h0ABCD_005;  // V W, dirty clear
    mem[leaf_loc(1, 3)]    = 32'h00777_009;  // V X
    mem[leaf_loc(1, 4)]    = 32'h00555_00D;  // V W X
    mem[leaf_loc(1, 5)]    = 32'h00555_00B;  // V R X
    mem[leaf_loc(1, 6)]    = 32'h00555_007;  // V R W
    mem[leaf_loc(1, 7)]    = 32'h00555_01F;  // all
    mem[leaf_loc(1, 8)]    = 32'h00666_00E;  // not valid
    mem[leaf_loc(1023, 1023)] = 32'hFEDCB_003;
    mem[leaf_loc(0, 0)]    = 32'h00001_00F;

    send(32'h0040_1234, 2'd0, b, "R6");            // read permitted (R3 leaf address)
    send(32'h0040_2010, 2'd1, b, "R7");            // write, dirty clear: write-back
    send(32'h0040_2FF0, 2'd1, b, "R7");            // same page again: dirty now set
    send(32'h0040_3FFC, 2'd2, b, "R6");            // execute permitted
    send(32'h0040_4000, 2'd0, b, "R5");            // read denied
    send(32'h0040_5008, 2'd1, b, "R5");            // write denied, no write-back
    send(32'h0040_6100, 2'd2, b, "R5");            // execute denied
    send(32'h0040_7000, 2'd3, b, "R5");            // reserved kind on full rights
    send(32'h0040_8000, 2'd0, b, "R4");            // leaf invalid
    send(32'h0080_0000, 2'd0, b, "R4");            // directory invalid
    send(32'hFFFF_FFFF, 2'd0, b, "R3");            // top indices, top offset
    send(32'h0000_0ABC, 2'd2, b, "R6");            // zero indices
    send(32'h0040_1FFF, 2'd0, b | 32'hFFF, "R2");  // junk in base low bits
    send(32'h0040_7ABC, 2'd1, b, "R9");            // write with dirty already set

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule